// File: doc/BRIEF.md
# Banked Shared Memory Conflict Resolver

This block is a word-interleaved scratch memory spread over sixteen single-ported banks. Each bank can serve one 32-bit word per clock. A sixteen-lane client sends one gathered request per transaction. The request carries a word address for every lane, a lane-enable mask, and a read/write flag. The block breaks the request into as few bank passes as the address pattern allows, then returns every lane's data at once.

In a pass, each bank looks at the pending lanes that fall into it. It serves the address of the lowest-numbered one, and every other pending lane that asks for that same word rides along. Lanes that share a word therefore never conflict. Strides that are odd, and so coprime with the bank count, spread over all banks and finish in one pass. Writes follow the same schedule. When several lanes write one word, the highest-numbered lane wins.

The client waits for `busy` to fall before it offers the next request. It takes the results in the cycle `rsp_done` is high.

Top module: `bank_conflict_mem`

## Requirements
- R1: After reset, `busy` and `rsp_done` are low and `rsp_passes` is zero.
- R2: A word's bank is its address modulo 16 (the low four address bits), and its row is the remaining upper bits. A request in which every active lane names a different bank completes in one pass. This holds for ascending, descending and unaligned patterns.
- R3: Active lanes that name the same word are served in the same pass, each receiving that word, and add no passes.
- R4: The pass count equals the largest number of distinct addresses that any one bank receives. A word stride of 2 takes 2 passes, a stride of 16 takes one pass per active lane, and a stride of 17 takes 1 pass.
- R5: A request is taken at a rising edge where `req_valid` is high and `busy` is low. With P passes, `busy` is high for the P cycles after that edge. `rsp_done` is high for exactly the one cycle after the P-th edge, and `busy` is low in that cycle.
- R6: When `rsp_done` is high, `rsp_rdata` holds the addressed word for each active lane of a read. Every inactive lane of a read returns zero, and every lane of a write request returns zero. The values stay until the next request is taken.
- R7: A write stores each active lane's data at its address using the same pass schedule. When several active lanes write one address, the data of the highest-numbered such lane is stored.
- R8: While `busy` is high, `req_valid` and the request fields have no effect on memory contents or on the results of the running request.
- R9: A request with an all-zero mask reports done in the cycle after it is taken, with zero passes, and changes no memory word.
- R10: Every pass serves at least one pending lane and only lanes still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered this cycle |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_mask | input | 16 | Lane enable, bit n for lane n |
| req_addr | input | 160 | Lane word addresses, lane n at bits [10n+9:10n] |
| req_wdata | input | 512 | Lane write data, lane n at bits [32n+31:32n] |
| busy | output | 1 | A request is being served; new requests are ignored |
| rsp_done | output | 1 | One-cycle flag: results and pass count are final |
| rsp_passes | output | 5 | Number of bank passes the last request used |
| rsp_rdata | output | 512 | Lane read data, lane n at bits [32n+31:32n] |

## Verification
A wrong pending mask or a faulty bank pick shows at the ports as a pass count off by one or more. It also moves `rsp_done` one or more cycles early or late. Both are visible in the very cycle that done was due. A broken lane-to-bank read mux, or a write merge that picks the wrong lane, appears as wrong lane data. That happens either at once in the done cycle, or at the next read of the affected word. A request that leaks in while busy shows up when the words it would have overwritten are read back.

// File: rtl/smp_pkg.sv
package smp_pkg;
   // Direction of a latched request
   typedef enum logic {
      OP_READ  = 1'b0,
      OP_WRITE = 1'b1
   } smp_op_e;
endpackage

// File: rtl/smp_bank_pick.sv
// Per-bank pass scheduler: selects the address of the lowest pending lane
// that maps here and grants every pending lane sharing that address.
module smp_bank_pick #(
   parameter int LANES   = 16,
   parameter int ADDR_W  = 10,
   parameter int DATA_W  = 32,
   parameter int BANK_W  = 4,
   parameter int BANK_ID = 0,
   localparam int ROW_W  = ADDR_W - BANK_W
) (
   input  logic [LANES-1:0]        pend,
   input  logic [LANES*ADDR_W-1:0] lane_addr,
   input  logic [LANES*DATA_W-1:0] lane_wdata,
   output logic [LANES-1:0]        grant,
   output logic                    active,
   output logic [ROW_W-1:0]        row,
   output logic [DATA_W-1:0]       wdata
);
   logic [LANES-1:0]  hit;
   logic [ADDR_W-1:0] lead_addr;
   logic              found;

   always_comb begin
      hit = '0;
      for (int l = 0; l < LANES; l++) begin
         hit[l] = pend[l] &&
                  (lane_addr[l*ADDR_W +: BANK_W] == BANK_W'(BANK_ID));
      end
   end

   always_comb begin
      found     = 1'b0;
      lead_addr = '0;
      for (int l = 0; l < LANES; l++) begin
         if (hit[l] && !found) begin
            found     = 1'b1;
            lead_addr = lane_addr[l*ADDR_W +: ADDR_W];
         end
      end
   end

   always_comb begin
      grant = '0;
      wdata = '0;
      for (int l = 0; l < LANES; l++) begin
         grant[l] = hit[l] && (lane_addr[l*ADDR_W +: ADDR_W] == lead_addr);
         if (grant[l]) wdata = lane_wdata[l*DATA_W +: DATA_W];  // highest lane wins
      end
   end

   assign active = found;
   assign row    = lead_addr[ADDR_W-1:BANK_W];
endmodule

// File: rtl/smp_bank_ram.sv
// One bank: a single word port, asynchronous read, write at the clock edge.
module smp_bank_ram #(
   parameter int DATA_W = 32,
   parameter int ROW_W  = 6,
   localparam int ROWS  = 1 << ROW_W
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ROW_W-1:0]  row,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [ROWS];

   always_ff @(posedge clk) begin
      if (we) mem[row] <= wdata;
   end

   assign rdata = mem[row];
endmodule

// File: rtl/bank_conflict_mem.sv
module bank_conflict_mem #(
   parameter int LANES  = 16,
   parameter int BANKS  = 16,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 10,
   localparam int BANK_W = $clog2(BANKS),
   localparam int ROW_W  = ADDR_W - BANK_W,
   localparam int PASS_W = $clog2(LANES + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   input  logic                    req_write,
   input  logic [LANES-1:0]        req_mask,
   input  logic [LANES*ADDR_W-1:0] req_addr,
   input  logic [LANES*DATA_W-1:0] req_wdata,
   output logic                    busy,
   output logic                    rsp_done,
   output logic [PASS_W-1:0]       rsp_passes,
   output logic [LANES*DATA_W-1:0] rsp_rdata
);
   import smp_pkg::*;

   // elaboration-time parameter checks
   if (BANKS < 2 || (1 << BANK_W) != BANKS) begin : g_bad_banks
      $error("BANKS must be a power of two of at least 2");
   end
   if (ROW_W < 1) begin : g_bad_addr
      $error("ADDR_W must exceed log2(BANKS)");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be positive");
   end

   logic                    busy_q, done_q;
   smp_op_e                 op_q;
   logic [LANES-1:0]        pend_q;
   logic [LANES*ADDR_W-1:0] addr_q;
   logic [LANES*DATA_W-1:0] wdata_q;
   logic [LANES*DATA_W-1:0] rdata_q;
   logic [PASS_W-1:0]       passes_q;

   logic [LANES-1:0]  grant_b [BANKS];
   logic              act_b   [BANKS];
   logic [ROW_W-1:0]  row_b   [BANKS];
   logic [DATA_W-1:0] wd_b    [BANKS];
   logic [DATA_W-1:0] rd_b    [BANKS];
   logic [LANES-1:0]  served;
   logic [LANES-1:0]  pend_nx;
   logic [DATA_W-1:0] lane_rd [LANES];

   for (genvar g = 0; g < BANKS; g++) begin : g_bank
      smp_bank_pick #(
         .LANES(LANES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
         .BANK_W(BANK_W), .BANK_ID(g)
      ) u_pick (
         .pend(pend_q), .lane_addr(addr_q), .lane_wdata(wdata_q),
         .grant(grant_b[g]), .active(act_b[g]), .row(row_b[g]), .wdata(wd_b[g])
      );
      smp_bank_ram #(.DATA_W(DATA_W), .ROW_W(ROW_W)) u_ram (
         .clk(clk),
         .we(busy_q && (op_q == OP_WRITE) && act_b[g]),
         .row(row_b[g]), .wdata(wd_b[g]), .rdata(rd_b[g])
      );
   end

   always_comb begin
      served = '0;
      for (int b = 0; b < BANKS; b++) served = served | grant_b[b];
   end

   assign pend_nx = pend_q & ~served;

   // route each lane to the read port of its own bank
   always_comb begin
      for (int l = 0; l < LANES; l++) begin
         lane_rd[l] = rd_b[addr_q[l*ADDR_W +: BANK_W]];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         done_q   <= 1'b0;
         op_q     <= OP_READ;
         pend_q   <= '0;
         addr_q   <= '0;
         wdata_q  <= '0;
         rdata_q  <= '0;
         passes_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (req_valid) begin
               addr_q   <= req_addr;
               wdata_q  <= req_wdata;
               op_q     <= req_write ? OP_WRITE : OP_READ;
               pend_q   <= req_mask;
               rdata_q  <= '0;
               passes_q <= '0;
               if (req_mask == '0) done_q <= 1'b1;
               else                busy_q <= 1'b1;
            end
         end else begin
            pend_q   <= pend_nx;
            passes_q <= passes_q + PASS_W'(1);
            if (op_q == OP_READ) begin
               for (int l = 0; l < LANES; l++) begin
                  if (served[l]) rdata_q[l*DATA_W +: DATA_W] <= lane_rd[l];
               end
            end
            if (pend_nx == '0) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign busy       = busy_q;
   assign rsp_done   = done_q;
   assign rsp_passes = passes_q;
   assign rsp_rdata  = rdata_q;

   AST_PASS_SERVES: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (served != '0) && ((served & ~pend_q) == '0)); // R10
   AST_PEND_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> !busy_q || ($countones(pend_q) < $past($countones(pend_q)))); // R10
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> !busy); // R5
   AST_PASS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> (int'(rsp_passes) <= LANES)); // R4
   AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && op_q == OP_WRITE) |-> (rsp_rdata == '0)); // R6
   AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q)) |-> ($stable(addr_q) && $stable(wdata_q))); // R8
endmodule

// File: tb/bank_conflict_mem_test.sv
module bank_conflict_mem_test;
   localparam int LN = 16;
   localparam int DW = 32;
   localparam int AW = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic             req_valid = 1'b0;
   logic             req_write = 1'b0;
   logic [LN-1:0]    req_mask  = '0;
   logic [LN*AW-1:0] req_addr  = '0;
   logic [LN*DW-1:0] req_wdata = '0;
   logic             busy, rsp_done;
   logic [4:0]       rsp_passes;
   logic [LN*DW-1:0] rsp_rdata;

   bank_conflict_mem uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_mask(req_mask), .req_addr(req_addr), .req_wdata(req_wdata),
      .busy(busy), .rsp_done(rsp_done), .rsp_passes(rsp_passes), .rsp_rdata(rsp_rdata)
   );

   int          checks = 0;
   int          errors = 0;
   logic [31:0] mdl [1024];
   int          a_addr [LN];
   logic [31:0] a_wd [LN];

   task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   // reference pass count: most distinct addresses landing on one bank
   function automatic int exp_passes(input logic [LN-1:0] m);
      int worst = 0;
      for (int b = 0; b < 16; b++) begin
         int cnt = 0;
         for (int l = 0; l < LN; l++) begin
            bit dup = 0;
            if (!m[l] || (a_addr[l] % 16) != b) continue;
            for (int j = 0; j < l; j++)
               if (m[j] && a_addr[j] == a_addr[l]) dup = 1;
            if (!dup) cnt++;
         end
         if (cnt > worst) worst = cnt;
      end
      return worst;
   endfunction

   task automatic run(input bit wr, input logic [LN-1:0] m, input bit intrude,
                      input string rq);
      int p = exp_passes(m);
      @(negedge clk);
      chk(busy == 1'b0, {rq, " idle before request"}, 32'(busy), 0);
      req_write = wr;
      req_mask  = m;
      for (int l = 0; l < LN; l++) begin
         req_addr[l*AW +: AW]  = AW'(a_addr[l]);
         req_wdata[l*DW +: DW] = a_wd[l];
      end
      req_valid = 1'b1;
      @(posedge clk);
      for (int k = 0; k <= p; k++) begin
         @(negedge clk);
         if (intrude && k < p) begin
            req_write = 1'b1;
            req_mask  = '1;
            for (int l = 0; l < LN; l++) begin
               req_addr[l*AW +: AW]  = AW'((a_addr[l] + 3) % 1024);
               req_wdata[l*DW +: DW] = 32'hDEAD_0000 + 32'(l);
            end
            req_valid = 1'b1;
         end else begin
            req_valid = 1'b0;
         end
         chk(rsp_done == (k == p), {rq, " done timing (R5)"}, 32'(rsp_done), 32'(k == p));
         chk(busy == (k < p), {rq, " busy timing (R5)"}, 32'(busy), 32'(k < p));
      end
      chk(rsp_passes == 5'(p), {rq, " pass count"}, 32'(rsp_passes), 32'(p));
      for (int l = 0; l < LN; l++) begin
         logic [31:0] e = (!wr && m[l]) ? mdl[a_addr[l]] : 32'h0;
         chk(rsp_rdata[l*DW +: DW] == e, {rq, " lane data (R6)"}, rsp_rdata[l*DW +: DW], e);
      end
      if (wr) for (int l = 0; l < LN; l++) if (m[l]) mdl[a_addr[l]] = a_wd[l];
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(busy == 0, "R1 busy", 32'(busy), 0);
      chk(rsp_done == 0, "R1 done", 32'(rsp_done), 0);
      chk(rsp_passes == 0, "R1 passes", 32'(rsp_passes), 0);
      rst_n = 1'b1;

      // R7: fill all words, one contiguous block per request
      for (int blk = 0; blk < 64; blk++) begin
         for (int l = 0; l < LN; l++) begin
            a_addr[l] = blk * 16 + l;
            a_wd[l]   = 32'h1000_0000 ^ (32'(a_addr[l]) * 32'h0001_0003);
         end
         run(1, '1, 0, "R7 fill");
      end

      for (int l = 0; l < LN; l++) a_addr[l] = 100 + l;
      run(0, '1, 0, "R2 ascending");
      for (int l = 0; l < LN; l++) a_addr[l] = 515 - l;
      run(0, '1, 0, "R2 descending");
      for (int l = 0; l < LN; l++) a_addr[l] = 1 + l;
      run(0, '1, 0, "R2 unaligned");

      for (int l = 0; l < LN; l++) a_addr[l] = 2 * l + 7;
      run(0, '1, 0, "R4 stride2");
      for (int l = 0; l < LN; l++) a_addr[l] = 16 * l + 5;
      run(0, '1, 0, "R4 stride16");
      for (int l = 0; l < LN; l++) a_addr[l] = 17 * l;
      run(0, '1, 0, "R4 stride17");
      for (int l = 0; l < LN; l++) a_addr[l] = (l < 8) ? 64 : 80 + 16 * (l - 8);
      run(0, '1, 0, "R4 mixed shared and strided");

      for (int l = 0; l < LN; l++) a_addr[l] = 300;
      run(0, '1, 0, "R3 broadcast");
      for (int l = 0; l < LN; l++) a_addr[l] = 400 + (l & ~1);
      run(0, '1, 0, "R3 pairs");

      for (int l = 0; l < LN; l++) a_addr[l] = 16 * l + 9;
      run(0, 16'h0115, 0, "R6 partial mask");
      run(0, 16'h0000, 0, "R9 empty read");
      for (int l = 0; l < LN; l++) begin a_addr[l] = 16 * l + 9; a_wd[l] = 32'hBAD0_0000 + 32'(l); end
      run(1, 16'h0000, 0, "R9 empty write");
      run(0, '1, 0, "R9 memory unchanged");

      for (int l = 0; l < LN; l++) begin a_addr[l] = 700; a_wd[l] = 32'hC0DE_0000 + 32'(l); end
      run(1, '1, 0, "R7 same-address write");
      run(0, '1, 0, "R7 highest lane kept");
      for (int l = 0; l < LN; l++) begin a_addr[l] = 16 * l + 3; a_wd[l] = 32'h5EED_0000 + 32'(l); end
      run(1, '1, 0, "R7 stride16 write");
      run(0, '1, 0, "R7 stride16 readback");

      for (int l = 0; l < LN; l++) a_addr[l] = 2 * l + 7;
      run(0, '1, 1, "R8 request during busy");
      for (int l = 0; l < LN; l++) a_addr[l] = 2 * l + 10;
      run(0, '1, 0, "R8 words untouched");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule